// File: doc/BRIEF.md
# Operand Hazard and Bypass Unit

This unit sits beside the decode stage of a five-stage in-order integer pipeline. Every cycle it compares the two source register numbers of the decoding instruction against the destination of the instruction one stage ahead (execute) and two stages ahead (memory). A comparison only counts when the decoding instruction actually consumes that source, either as an ALU operand or as a branch or register-jump operand. The unit then produces three things: per-operand bypass selects together with the selected ALU operand values, decode-side bypass values for branch comparison, and a stall that freezes fetch.

The unit also owns the control half of the decode-to-execute register: the write enable, destination number and load flag of the instruction that moves into execute. On a stall that register takes a bubble with all flags cleared. Its contents are exported and are also the execute-stage side of the next cycle's comparison. The execute stage's ALU result and the memory stage's write enable, destination and write-back value come in from the surrounding pipeline. No write-back stage comparison is made, because the register file returns a value written in a cycle to a read in that same cycle.

A two-bit mode input selects the policy: no hazard handling, stall only, or stall with bypassing.

Top module: `hazard_bypass_unit`

## Requirements
- R1: A source operand conflicts with a stage only when that stage's write enable is 1, its destination is not register 0, its destination equals the operand's register number, and the decoding instruction marks that operand as used (ALU use or branch use). An operand with no such conflict never causes a stall or a bypass.
- R2: With mode 2'b00 (no handling), stall is 0, both bypass selects are 2'b00, both branch bypass flags are 0, and the operand outputs equal the register-file values.
- R3: With mode 2'b01 (stall only), any conflict of a used operand with the execute or the memory stage raises stall. The bypass selects and branch bypass flags stay 0.
- R4: With mode 2'b10 or 2'b11 (bypass), the select for an ALU-used operand is 2'b10 when it conflicts with a non-load execute instruction. Otherwise it is 2'b01 when it conflicts with the memory stage, and otherwise 2'b00. The execute stage wins when both stages match. The ALU operand outputs carry the execute result, the memory write-back value or the register-file value for select values 2'b10, 2'b01 and 2'b00.
- R5: In bypass mode an ALU-used operand that conflicts with a load in execute raises stall.
- R6: In modes 2'b01, 2'b10 and 2'b11 a branch-used operand that conflicts with the execute stage raises stall.
- R7: In bypass mode a branch-used operand that conflicts with the memory stage sets its own flag (br_fwd_rs or br_fwd_rt), and the matching branch value output carries the memory write-back value. With the flag clear, the branch value output is the register-file value. In stall-only mode the same conflict raises stall instead.
- R8: The decode-to-execute control register clears to all zeros on reset. At a clock edge where stall is 1 it loads a bubble (write enable 0, destination 0, load 0). At any other edge it captures the decoding instruction's write enable, destination and load flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 none, 01 stall only, 1x stall with bypass |
| id_rs | input | 5 | First source register number in decode |
| id_rt | input | 5 | Second source register number in decode |
| id_rs_alu | input | 1 | First source used as ALU operand |
| id_rt_alu | input | 1 | Second source used as ALU operand |
| id_rs_br | input | 1 | First source used by branch or register jump |
| id_rt_br | input | 1 | Second source used by branch |
| id_rs_val | input | 32 | Register-file value of first source |
| id_rt_val | input | 32 | Register-file value of second source |
| id_wen | input | 1 | Decoding instruction writes a register |
| id_dst | input | 5 | Destination of decoding instruction |
| id_load | input | 1 | Decoding instruction is a load |
| ex_result | input | 32 | ALU result of execute stage |
| mem_wen | input | 1 | Memory-stage write enable |
| mem_dst | input | 5 | Memory-stage destination |
| mem_result | input | 32 | Memory-stage write-back value |
| stall | output | 1 | Hold fetch and insert bubble |
| fwd_rs_sel | output | 2 | Bypass select for first ALU operand |
| fwd_rt_sel | output | 2 | Bypass select for second ALU operand |
| alu_rs_val | output | 32 | First ALU operand after bypass |
| alu_rt_val | output | 32 | Second ALU operand after bypass |
| br_fwd_rs | output | 1 | Memory-to-decode bypass on first branch operand |
| br_fwd_rt | output | 1 | Memory-to-decode bypass on second branch operand |
| br_rs_val | output | 32 | First branch operand after bypass |
| br_rt_val | output | 32 | Second branch operand after bypass |
| ex_wen | output | 1 | Execute-stage write enable (registered) |
| ex_dst | output | 5 | Execute-stage destination (registered) |
| ex_load | output | 1 | Execute-stage load flag (registered) |

## Verification
Stall, the bypass selects and all operand values are combinational in the decode inputs, the memory-stage inputs and the registered execute state, so they are due in the same cycle as the stimulus. The bench drives on the falling edge and compares them two nanoseconds later, well before the next rising edge. The execute-stage outputs are due one rising edge later. The bench's own copy of that register is updated just after each rising edge from the stall it predicted, and it is compared in the following cycle. A dependent instruction placed one cycle behind its producer therefore meets it in execute, and one placed two cycles behind meets it in memory.

// File: rtl/hazard_bypass_unit.sv
module hazard_bypass_unit #(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic [RW-1:0]   id_rs,
  input  logic [RW-1:0]   id_rt,
  input  logic            id_rs_alu,
  input  logic            id_rt_alu,
  input  logic            id_rs_br,
  input  logic            id_rt_br,
  input  logic [XLEN-1:0] id_rs_val,
  input  logic [XLEN-1:0] id_rt_val,
  input  logic            id_wen,
  input  logic [RW-1:0]   id_dst,
  input  logic            id_load,
  input  logic [XLEN-1:0] ex_result,
  input  logic            mem_wen,
  input  logic [RW-1:0]   mem_dst,
  input  logic [XLEN-1:0] mem_result,
  output logic            stall,
  output logic [1:0]      fwd_rs_sel,
  output logic [1:0]      fwd_rt_sel,
  output logic [XLEN-1:0] alu_rs_val,
  output logic [XLEN-1:0] alu_rt_val,
  output logic            br_fwd_rs,
  output logic            br_fwd_rt,
  output logic [XLEN-1:0] br_rs_val,
  output logic [XLEN-1:0] br_rt_val,
  output logic            ex_wen,
  output logic [RW-1:0]   ex_dst,
  output logic            ex_load
);

  localparam logic [1:0] SEL_NONE = 2'b00;
  localparam logic [1:0] SEL_MEM  = 2'b01;
  localparam logic [1:0] SEL_EX   = 2'b10;
  localparam logic [RW-1:0] R0    = '0;

  logic mode_stall, mode_fwd;
  assign mode_stall = (mode == 2'b01);
  assign mode_fwd   = mode[1];

  logic ex_live, mem_live;
  assign ex_live  = ex_wen && (ex_dst != R0);
  assign mem_live = mem_wen && (mem_dst != R0);

  logic ex_hit_rs, ex_hit_rt, mem_hit_rs, mem_hit_rt;
  assign ex_hit_rs  = ex_live && (ex_dst == id_rs);
  assign ex_hit_rt  = ex_live && (ex_dst == id_rt);
  assign mem_hit_rs = mem_live && (mem_dst == id_rs);
  assign mem_hit_rt = mem_live && (mem_dst == id_rt);

  logic use_rs, use_rt;
  assign use_rs = id_rs_alu || id_rs_br;
  assign use_rt = id_rt_alu || id_rt_br;

  logic stall_only_req;
  assign stall_only_req = mode_stall &&
    ((use_rs && (ex_hit_rs || mem_hit_rs)) || (use_rt && (ex_hit_rt || mem_hit_rt)));

  logic load_use, branch_ex;
  assign load_use  = ex_load && ((id_rs_alu && ex_hit_rs) || (id_rt_alu && ex_hit_rt));
  assign branch_ex = (id_rs_br && ex_hit_rs) || (id_rt_br && ex_hit_rt);

  assign stall = stall_only_req || (mode_fwd && (load_use || branch_ex));

  always_comb begin
    fwd_rs_sel = SEL_NONE;
    if (mode_fwd && id_rs_alu) begin
      if (ex_hit_rs && !ex_load) fwd_rs_sel = SEL_EX;
      else if (mem_hit_rs)       fwd_rs_sel = SEL_MEM;
    end
  end

  always_comb begin
    fwd_rt_sel = SEL_NONE;
    if (mode_fwd && id_rt_alu) begin
      if (ex_hit_rt && !ex_load) fwd_rt_sel = SEL_EX;
      else if (mem_hit_rt)       fwd_rt_sel = SEL_MEM;
    end
  end

  assign alu_rs_val = (fwd_rs_sel == SEL_EX)  ? ex_result :
                      (fwd_rs_sel == SEL_MEM) ? mem_result : id_rs_val;
  assign alu_rt_val = (fwd_rt_sel == SEL_EX)  ? ex_result :
                      (fwd_rt_sel == SEL_MEM) ? mem_result : id_rt_val;

  assign br_fwd_rs = mode_fwd && id_rs_br && mem_hit_rs;
  assign br_fwd_rt = mode_fwd && id_rt_br && mem_hit_rt;
  assign br_rs_val = br_fwd_rs ? mem_result : id_rs_val;
  assign br_rt_val = br_fwd_rt ? mem_result : id_rt_val;

  always_ff @(posedge clk) begin
    if (!rst_n || stall) begin
      ex_wen  <= 1'b0;
      ex_dst  <= R0;
      ex_load <= 1'b0;
    end else begin
      ex_wen  <= id_wen;
      ex_dst  <= id_dst;
      ex_load <= id_load;
    end
  end

  assert_off_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (!stall && fwd_rs_sel == 2'b00 && fwd_rt_sel == 2'b00 &&
                         !br_fwd_rs && !br_fwd_rt && alu_rs_val == id_rs_val));

  assert_stall_mode_no_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (fwd_rs_sel == 2'b00 && fwd_rt_sel == 2'b00 && !br_fwd_rs && !br_fwd_rt));

  assert_sel_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fwd_rs_sel) && $onehot0(fwd_rt_sel));

  assert_ex_bypass_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_rs_sel == 2'b10) |-> (alu_rs_val == ex_result));

  assert_load_use_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && ex_load && ex_wen && ex_dst != R0 && id_rs_alu && id_rs == ex_dst) |-> stall);

  assert_branch_ex_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && ex_wen && ex_dst != R0 && id_rt_br && id_rt == ex_dst) |-> stall);

  assert_branch_mem_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_fwd_rt |-> (br_rt_val == mem_result && mem_wen));

  assert_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!ex_wen && !ex_load && ex_dst == R0));

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (ex_wen == $past(id_wen) && ex_dst == $past(id_dst) && ex_load == $past(id_load)));

endmodule

// File: tb/hazard_bypass_unit_tb.sv
module hazard_bypass_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [4:0]  id_rs = '0, id_rt = '0, id_dst = '0, mem_dst = '0;
  logic        id_rs_alu = 0, id_rt_alu = 0, id_rs_br = 0, id_rt_br = 0;
  logic        id_wen = 0, id_load = 0, mem_wen = 0;
  logic [31:0] id_rs_val = '0, id_rt_val = '0, ex_result = '0, mem_result = '0;
  logic        stall, br_fwd_rs, br_fwd_rt, ex_wen, ex_load;
  logic [1:0]  fwd_rs_sel, fwd_rt_sel;
  logic [31:0] alu_rs_val, alu_rt_val, br_rs_val, br_rt_val;
  logic [4:0]  ex_dst;

  int n_chk = 0;
  int n_bad = 0;

  logic       m_wen = 0, m_load = 0;
  logic [4:0] m_dst = '0;
  logic       e_stall;

  always #5 clk = ~clk;

  hazard_bypass_unit dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .id_rs(id_rs), .id_rt(id_rt), .id_rs_alu(id_rs_alu), .id_rt_alu(id_rt_alu),
    .id_rs_br(id_rs_br), .id_rt_br(id_rt_br), .id_rs_val(id_rs_val), .id_rt_val(id_rt_val),
    .id_wen(id_wen), .id_dst(id_dst), .id_load(id_load), .ex_result(ex_result),
    .mem_wen(mem_wen), .mem_dst(mem_dst), .mem_result(mem_result),
    .stall(stall), .fwd_rs_sel(fwd_rs_sel), .fwd_rt_sel(fwd_rt_sel),
    .alu_rs_val(alu_rs_val), .alu_rt_val(alu_rt_val),
    .br_fwd_rs(br_fwd_rs), .br_fwd_rt(br_fwd_rt), .br_rs_val(br_rs_val), .br_rt_val(br_rt_val),
    .ex_wen(ex_wen), .ex_dst(ex_dst), .ex_load(ex_load)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic hit(input logic w, input logic [4:0] d, input logic [4:0] s);
    return w && d != 5'd0 && d == s;
  endfunction

  function automatic logic [1:0] exp_sel(input logic alu, input logic eh, input logic mh);
    if (!mode[1] || !alu) return 2'b00;
    if (eh && !m_load) return 2'b10;
    if (mh) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf);
    return (s == 2'b10) ? ex_result : (s == 2'b01) ? mem_result : rf;
  endfunction

  task automatic check_now();
    logic ehs, eht, mhs, mht, us, ut, bfs, bft;
    logic [1:0] ss, st;
    ehs = hit(m_wen, m_dst, id_rs);
    eht = hit(m_wen, m_dst, id_rt);
    mhs = hit(mem_wen, mem_dst, id_rs);
    mht = hit(mem_wen, mem_dst, id_rt);
    us = id_rs_alu || id_rs_br;
    ut = id_rt_alu || id_rt_br;
    e_stall = 1'b0;
    if (mode == 2'b01)
      e_stall = (us && (ehs || mhs)) || (ut && (eht || mht));
    else if (mode[1])
      e_stall = (m_load && ((id_rs_alu && ehs) || (id_rt_alu && eht))) ||
                (id_rs_br && ehs) || (id_rt_br && eht);
    ss = exp_sel(id_rs_alu, ehs, mhs);
    st = exp_sel(id_rt_alu, eht, mht);
    bfs = mode[1] && id_rs_br && mhs;
    bft = mode[1] && id_rt_br && mht;
    chk("R1 R2 R3 R5 R6 stall", {31'd0, stall}, {31'd0, e_stall});
    chk("R1 R4 fwd_rs_sel", {30'd0, fwd_rs_sel}, {30'd0, ss});
    chk("R1 R4 fwd_rt_sel", {30'd0, fwd_rt_sel}, {30'd0, st});
    chk("R4 alu_rs_val", alu_rs_val, pick(ss, id_rs_val));
    chk("R4 alu_rt_val", alu_rt_val, pick(st, id_rt_val));
    chk("R7 br_fwd_rs", {31'd0, br_fwd_rs}, {31'd0, bfs});
    chk("R7 br_fwd_rt", {31'd0, br_fwd_rt}, {31'd0, bft});
    chk("R7 br_rs_val", br_rs_val, bfs ? mem_result : id_rs_val);
    chk("R7 br_rt_val", br_rt_val, bft ? mem_result : id_rt_val);
    chk("R8 ex_ctrl", {25'd0, ex_wen, ex_dst, ex_load}, {25'd0, m_wen, m_dst, m_load});
  endtask

  task automatic step();
    #2;
    check_now();
    @(posedge clk);
    #1;
    if (e_stall) begin
      m_wen = 0; m_dst = '0; m_load = 0;
    end else begin
      m_wen = id_wen; m_dst = id_dst; m_load = id_load;
    end
    @(negedge clk);
  endtask

  task automatic set_dec(input logic [4:0] rs, input logic [4:0] rt, input logic ra, input logic ta,
                         input logic rb, input logic tb, input logic w, input logic [4:0] d,
                         input logic ld);
    id_rs = rs; id_rt = rt; id_rs_alu = ra; id_rt_alu = ta; id_rs_br = rb; id_rt_br = tb;
    id_wen = w; id_dst = d; id_load = ld;
    id_rs_val = $urandom; id_rt_val = $urandom;
    ex_result = $urandom; mem_result = $urandom;
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #2;
    chk("R8 reset ex_ctrl", {25'd0, ex_wen, ex_dst, ex_load}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (mode[i]) ;
    for (int m = 1; m < 4; m++) begin
      mode = m[1:0];
      // R4 back-to-back dependent ALU ops: producer r3, then consumer of r3 on both operands
      mem_wen = 0; mem_dst = 0;
      set_dec(5'd1, 5'd2, 1, 1, 0, 0, 1, 5'd3, 0); step();
      set_dec(5'd3, 5'd3, 1, 1, 0, 0, 1, 5'd4, 0); step();
      // R4 priority: execute and memory both write r4
      mem_wen = 1; mem_dst = 5'd4;
      set_dec(5'd4, 5'd9, 1, 1, 0, 0, 0, 5'd0, 0); step();
      // R5 load then immediate use
      mem_wen = 0;
      set_dec(5'd1, 5'd2, 1, 1, 0, 0, 1, 5'd7, 1); step();
      set_dec(5'd7, 5'd2, 1, 1, 0, 0, 1, 5'd8, 0); step();
      step();
      // R6 branch depends on instruction one stage ahead
      set_dec(5'd1, 5'd2, 1, 1, 0, 0, 1, 5'd5, 0); step();
      set_dec(5'd6, 5'd5, 0, 0, 1, 1, 0, 5'd0, 0); step();
      // R7 branch depends on instruction two stages ahead
      mem_wen = 1; mem_dst = 5'd6;
      set_dec(5'd6, 5'd6, 0, 0, 1, 1, 0, 5'd0, 0); step();
      // R1 register 0 never conflicts, unused operands never conflict
      mem_wen = 1; mem_dst = 5'd0;
      set_dec(5'd0, 5'd0, 1, 1, 1, 1, 1, 5'd0, 0); step();
      mem_dst = 5'd10;
      set_dec(5'd10, 5'd10, 0, 0, 0, 0, 0, 5'd0, 0); step();
    end
    // R2 no handling: same conflicts produce nothing
    mode = 2'b00;
    set_dec(5'd1, 5'd2, 1, 1, 0, 0, 1, 5'd3, 1); step();
    mem_wen = 1; mem_dst = 5'd3;
    set_dec(5'd3, 5'd3, 1, 1, 1, 1, 0, 5'd0, 0); step();

    for (int k = 0; k < 4000; k++) begin
      mode = 2'($urandom_range(0, 3));
      mem_wen = 1'($urandom); mem_dst = 5'($urandom_range(0, 3));
      set_dec(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 5'($urandom_range(0, 3)), 1'($urandom));
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule